// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block drives one pulse-width-modulated pin whose average duty cycle resolves to 12 or 14 bits while its internal counter stays only eight bits wide. Time is cut into sub-periods of 256 ticks. A base field of the setting word fixes how many ticks at the start of every sub-period the pin stays low. The remaining upper field names how many sub-periods out of one main period get one extra low tick. A main period holds 16 sub-periods in the narrow mode and 64 in the wide mode.

The extra ticks are not grouped together. Each sub-period index is mapped to one upper bit through the position of its lowest set bit, so the most significant upper bit covers every odd index and each lower bit covers half as many, evenly spaced indices. The ripple that the averaging filter after the pin has to remove is therefore spread across the whole main period. A tick is two or four clock cycles. The setting word, the resolution mode and the tick length are all taken over together when a main period begins, so a main period never mixes two settings.

Software writes a new setting through a single-cycle write strobe. The setting is held in a pending register until the current main period ends.

Top module: `dpwm_gen`

## Requirements
- R1: With the resolution select at 0 (narrow), a main period is 16 sub-periods. The low time over one main period is (n*16 + m) ticks, where n = data[BASE_W-1:0] and m = data[BASE_W+3:BASE_W]. Data bits above that 4-bit field have no effect in this mode.
- R2: With the resolution select at 1 (wide), a main period is 64 sub-periods. The low time over one main period is (n*64 + m) ticks, where m = data[BASE_W+5:BASE_W].
- R3: One tick lasts 2 clock cycles when the tick select is 0 and 4 clock cycles when it is 1.
- R4: A sub-period lasts 2^BASE_W ticks. The pin is low for the first n ticks of the sub-period, or n+1 ticks if the sub-period is selected for an extra tick, and is high for the rest.
- R5: A sub-period with index i > 0 gets the extra tick when upper bit m[U-1-p] is 1, where p is the position of the lowest set bit of i and U is 4 (narrow) or 6 (wide). Index 0 never gets an extra tick. All upper bits combine freely.
- R6: When the base field is all ones, the upper field is treated as 0, so the low time never fills a whole sub-period.
- R7: A write is held until the current main period ends. The new setting, the resolution select and the tick select all take effect together at the first sub-period (index 0) of the next main period.
- R8: After reset the active setting is zero: narrow mode, 2-cycle tick, n = 0, m = 0. The pin stays high until a written setting takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sel_i | input | 1 | Tick length: 0 = 2 clocks, 1 = 4 clocks; sampled at the start of a main period |
| wide_i | input | 1 | Resolution: 0 = 16 sub-periods, 1 = 64 sub-periods; sampled at the start of a main period |
| wr_en_i | input | 1 | Write strobe for the setting word |
| wr_data_i | input | BASE_W+WIDE_UP_W | Setting word: base width in the low BASE_W bits, dither count above them |
| pwm_o | output | 1 | PWM output pin, registered |

## Verification
A wrong base width or a wrong tick length changes the length of every low run, so it shows at the pin within one sub-period. A fault in the index-to-bit mapping keeps the run lengths legal but puts the extra ticks in the wrong sub-periods. This is seen only by recording a full main period of runs and matching them against the expected pattern under every phase. Counting and handover faults, such as a wrong sub-period count, a setting loaded mid-period, or a missing clamp, change the low-time total over one main period. That total is available after at most two main periods.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   // Tick length selector
   typedef enum logic {
      TICK_FAST = 1'b0,
      TICK_SLOW = 1'b1
   } tick_sel_e;

   // Resolution selector
   typedef enum logic {
      RES_NARROW = 1'b0,
      RES_WIDE   = 1'b1
   } res_mode_e;

endpackage

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler
   import dpwm_pkg::*;
#(
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  tick_sel_e sel,
   output logic      tick_en
);

   localparam int CNT_W = $clog2(SLOW_DIV);
   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

   if (FAST_DIV < 2 || SLOW_DIV <= FAST_DIV) begin : g_bad_div
      $error("dpwm_prescaler: need 2 <= FAST_DIV < SLOW_DIV");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last    = (sel == TICK_SLOW) ? SLOW_LAST : FAST_LAST;
   assign tick_en = (cnt_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_en) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: a tick never lasts a single clock
   a_r3_tick_gap : assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> !tick_en);

endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
   import dpwm_pkg::*;
#(
   parameter int BASE_W      = 8,
   parameter int NARROW_UP_W = 4,
   parameter int WIDE_UP_W   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  res_mode_e            mode,
   output logic [BASE_W-1:0]    tick_idx,
   output logic [WIDE_UP_W-1:0] sub_idx,
   output logic                 frame_end
);

   localparam logic [BASE_W-1:0]    TICK_LAST  = '1;
   localparam logic [WIDE_UP_W-1:0] SUB_LAST_W = '1;
   localparam logic [WIDE_UP_W-1:0] SUB_LAST_N = WIDE_UP_W'((1 << NARROW_UP_W) - 1);

   logic [WIDE_UP_W-1:0] sub_last;
   logic                 sub_end;

   assign sub_last  = (mode == RES_WIDE) ? SUB_LAST_W : SUB_LAST_N;
   assign sub_end   = tick_en && (tick_idx == TICK_LAST);
   assign frame_end = sub_end && (sub_idx >= sub_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_idx <= '0;
      end else if (tick_en) begin
         tick_idx <= tick_idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_idx <= '0;
      end else if (frame_end) begin
         sub_idx <= '0;
      end else if (sub_end) begin
         sub_idx <= sub_idx + 1'b1;
      end
   end

   // R1: narrow mode never walks past sub-period 15
   a_r1_narrow_range : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RES_NARROW) |-> (sub_idx <= SUB_LAST_N));

   // R7: every main period ends by returning to sub-period 0
   a_r7_frame_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (sub_idx == '0) && (tick_idx == '0));

endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither
   import dpwm_pkg::*;
#(
   parameter int NARROW_UP_W = 4,
   parameter int WIDE_UP_W   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  res_mode_e            mode,
   input  logic [WIDE_UP_W-1:0] sub_idx,
   input  logic [WIDE_UP_W-1:0] up_bits,
   output logic                 extra
);

   logic [WIDE_UP_W-1:0] lowest;
   logic [WIDE_UP_W-1:0] rev_wide;
   logic [WIDE_UP_W-1:0] rev_narrow;

   // one-hot of the lowest set bit of the index (zero for index 0)
   assign lowest = sub_idx & (~sub_idx + 1'b1);

   // bit reversal: index LSB position picks the most significant upper bit
   for (genvar b = 0; b < WIDE_UP_W; b++) begin : g_rev
      assign rev_wide[b] = up_bits[WIDE_UP_W-1-b];
      if (b < NARROW_UP_W) begin : g_in
         assign rev_narrow[b] = up_bits[NARROW_UP_W-1-b];
      end else begin : g_out
         assign rev_narrow[b] = 1'b0;
      end
   end

   assign extra = |(lowest & ((mode == RES_WIDE) ? rev_wide : rev_narrow));

   // R5: sub-period 0 never carries the extra tick
   a_r5_idx0_none : assert property (@(posedge clk) disable iff (!rst_n)
      (sub_idx == '0) |-> !extra);

   // R5: the selector addresses at most one upper bit
   a_r5_one_bit : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lowest));

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
   import dpwm_pkg::*;
#(
   parameter int BASE_W      = 8,
   parameter int NARROW_UP_W = 4,
   parameter int WIDE_UP_W   = 6,
   parameter int FAST_DIV    = 2,
   parameter int SLOW_DIV    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick_sel_i,
   input  logic                        wide_i,
   input  logic                        wr_en_i,
   input  logic [BASE_W+WIDE_UP_W-1:0] wr_data_i,
   output logic                        pwm_o
);

   localparam int DATA_W = BASE_W + WIDE_UP_W;
   localparam logic [BASE_W-1:0] BASE_FULL = '1;

   if (BASE_W < 2 || NARROW_UP_W < 1 || NARROW_UP_W >= WIDE_UP_W) begin : g_bad_cfg
      $error("dpwm_gen: need BASE_W >= 2 and 1 <= NARROW_UP_W < WIDE_UP_W");
   end

   // pending and active settings
   logic [DATA_W-1:0]    pend_q;
   logic [BASE_W-1:0]    act_n_q;
   logic [WIDE_UP_W-1:0] act_m_q;
   res_mode_e            act_mode_q;
   tick_sel_e            act_tick_q;

   logic [BASE_W-1:0]    ld_n;
   logic [WIDE_UP_W-1:0] ld_m_raw;
   logic [WIDE_UP_W-1:0] ld_m;

   logic                 tick_en;
   logic [BASE_W-1:0]    tick_idx;
   logic [WIDE_UP_W-1:0] sub_idx;
   logic                 frame_end;
   logic                 extra;
   logic [BASE_W:0]      low_width;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (wr_en_i) begin
         pend_q <= wr_data_i;
      end
   end

   // upper field as seen by the mode in force for the next main period
   assign ld_n = pend_q[BASE_W-1:0];
   always_comb begin
      if (wide_i) begin
         ld_m_raw = pend_q[DATA_W-1:BASE_W];
      end else begin
         ld_m_raw = '0;
         ld_m_raw[NARROW_UP_W-1:0] = pend_q[BASE_W +: NARROW_UP_W];
      end
   end
   assign ld_m = (ld_n == BASE_FULL) ? '0 : ld_m_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_n_q    <= '0;
         act_m_q    <= '0;
         act_mode_q <= RES_NARROW;
         act_tick_q <= TICK_FAST;
      end else if (frame_end) begin
         act_n_q    <= ld_n;
         act_m_q    <= ld_m;
         act_mode_q <= res_mode_e'(wide_i);
         act_tick_q <= tick_sel_e'(tick_sel_i);
      end
   end

   dpwm_prescaler #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (act_tick_q),
      .tick_en (tick_en)
   );

   dpwm_timebase #(
      .BASE_W      (BASE_W),
      .NARROW_UP_W (NARROW_UP_W),
      .WIDE_UP_W   (WIDE_UP_W)
   ) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .mode      (act_mode_q),
      .tick_idx  (tick_idx),
      .sub_idx   (sub_idx),
      .frame_end (frame_end)
   );

   dpwm_dither #(
      .NARROW_UP_W (NARROW_UP_W),
      .WIDE_UP_W   (WIDE_UP_W)
   ) u_dith (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (act_mode_q),
      .sub_idx (sub_idx),
      .up_bits (act_m_q),
      .extra   (extra)
   );

   assign low_width = {1'b0, act_n_q} + {{BASE_W{1'b0}}, extra};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_o <= 1'b1;
      end else begin
         pwm_o <= ({1'b0, tick_idx} >= low_width);
      end
   end

   // R6: a full base field never carries dither bits into the active set
   a_r6_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      (act_n_q == BASE_FULL) |-> (act_m_q == '0));

   // R7: the active setting only moves at a main-period boundary
   a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(act_n_q) && $stable(act_m_q)
                     && $stable(act_mode_q) && $stable(act_tick_q));

   // R4: ticks before the base width drive the pin low
   a_r4_low_head : assert property (@(posedge clk) disable iff (!rst_n)
      (tick_idx < act_n_q) |=> !pwm_o);

   // R4: ticks beyond base width plus one drive the pin high
   a_r4_high_tail : assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, tick_idx} > {1'b0, act_n_q}) |=> pwm_o);

endmodule

// File: tb/tb_dpwm_gen.sv
module tb_dpwm_gen;

   localparam int BW = 4;
   localparam int NU = 4;
   localparam int WU = 6;
   localparam int DW = BW + WU;
   localparam int TICKS = 1 << BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_sel_i = 1'b0;
   logic          wide_i = 1'b0;
   logic          wr_en_i = 1'b0;
   logic [DW-1:0] wr_data_i = '0;
   logic          pwm_o;

   int checks = 0;
   int fails  = 0;
   int cur_len = 16 * TICKS * 2;

   always #5 clk = ~clk;

   dpwm_gen #(
      .BASE_W      (BW),
      .NARROW_UP_W (NU),
      .WIDE_UP_W   (WU)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_sel_i (tick_sel_i),
      .wide_i     (wide_i),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .pwm_o      (pwm_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int tcyc(input logic ps);
      return ps ? 4 : 2;
   endfunction

   function automatic int nsub(input logic wide);
      return wide ? 64 : 16;
   endfunction

   function automatic int plen(input logic ps, input logic wide);
      return nsub(wide) * TICKS * tcyc(ps);
   endfunction

   function automatic int eff_m(input logic wide, input int n, input int m);
      if (n == TICKS - 1) return 0;
      return wide ? (m & 63) : (m & 15);
   endfunction

   function automatic int want_extra(input int i, input int m, input int u);
      int p;
      if (i == 0) return 0;
      p = 0;
      while (((i >> p) & 1) == 0) p++;
      return (m >> (u - 1 - p)) & 1;
   endfunction

   task automatic apply(input logic ps, input logic wide, input int n, input int m);
      @(negedge clk);
      tick_sel_i = ps;
      wide_i     = wide;
      wr_data_i  = DW'((m << BW) | n);
      wr_en_i    = 1'b1;
      @(negedge clk);
      wr_en_i    = 1'b0;
   endtask

   task automatic settle(input logic ps, input logic wide);
      repeat (cur_len + 4) @(negedge clk);
      cur_len = plen(ps, wide);
   endtask

   task automatic total(input string req, input logic ps, input logic wide,
                        input int n, input int m);
      int low;
      apply(ps, wide, n, m);
      settle(ps, wide);
      low = 0;
      repeat (plen(ps, wide)) begin
         @(negedge clk);
         if (!pwm_o) low++;
      end
      check(req, low, (n * nsub(wide) + eff_m(wide, n, m)) * tcyc(ps));
   endtask

   task automatic next_run(output int len);
      while (pwm_o == 1'b0) @(negedge clk);
      while (pwm_o == 1'b1) @(negedge clk);
      len = 0;
      while (pwm_o == 1'b0) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic pattern(input string req, input logic ps, input logic wide,
                          input int n, input int m);
      int s;
      int bad;
      int found;
      int lens[64];
      int obs[64];
      s = nsub(wide);
      apply(ps, wide, n, m);
      settle(ps, wide);
      bad = 0;
      for (int j = 0; j < s; j++) begin
         next_run(lens[j]);
         if (lens[j] == n * tcyc(ps)) obs[j] = 0;
         else if (lens[j] == (n + 1) * tcyc(ps)) obs[j] = 1;
         else begin
            obs[j] = 0;
            bad++;
         end
      end
      check({req, " run length"}, bad, 0);
      found = 0;
      for (int k = 0; k < s; k++) begin
         int ok;
         ok = 1;
         for (int j = 0; j < s; j++) begin
            if (obs[j] != want_extra((j + k) % s, m, wide ? WU : NU)) ok = 0;
         end
         if (ok != 0) found = 1;
      end
      check({req, " extra-tick placement"}, found, 1);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : stim
      int low;
      int len;
      int bad;
      int hit;

      // R8: pin high during and after reset while the zero setting is active
      repeat (4) @(negedge clk);
      check("R8 pin during reset", int'(pwm_o), 1);
      rst_n = 1'b1;
      low = 0;
      repeat (600) begin
         @(negedge clk);
         if (!pwm_o) low++;
      end
      check("R8 low cycles after reset", low, 0);

      // R1 / R3 narrow totals
      total("R1 R3 narrow fast n=5 m=3", 1'b0, 1'b0, 5, 3);
      total("R1 R3 narrow slow n=1 m=15", 1'b1, 1'b0, 1, 15);
      total("R1 narrow n=14 m=15", 1'b0, 1'b0, 14, 15);
      total("R1 narrow ignores bits above field", 1'b0, 1'b0, 3, 6'h3A);
      total("R6 narrow clamp n=15 m=15", 1'b0, 1'b0, 15, 15);

      // R4 / R3: every low run equals n ticks when m = 0
      apply(1'b0, 1'b0, 4, 0);
      settle(1'b0, 1'b0);
      bad = 0;
      for (int j = 0; j < 20; j++) begin
         next_run(len);
         if (len != 8) bad++;
      end
      check("R4 R3 narrow fast run length n=4", bad, 0);

      // R5 narrow placement
      pattern("R5 narrow m=1001", 1'b1, 1'b0, 6, 9);

      // R7: a write mid-period waits for sub-period 0 of the next period
      apply(1'b0, 1'b0, 3, 1);
      settle(1'b0, 1'b0);
      hit = 0;
      for (int j = 0; j < 40 && hit == 0; j++) begin
         next_run(len);
         if (len == 8) hit = 1;   // sub-period 8 is the only one with an extra tick
      end
      check("R7 marker run found", hit, 1);
      apply(1'b0, 1'b0, 5, 0);
      bad = 0;
      for (int j = 0; j < 7; j++) begin
         next_run(len);
         if (len != 6) bad++;
      end
      check("R7 old setting kept to end of period", bad, 0);
      next_run(len);
      check("R7 new setting at sub-period 0", len, 10);

      // R2 / R3 wide totals
      total("R2 wide fast n=7 m=37", 1'b0, 1'b1, 7, 37);
      total("R2 R3 wide slow n=2 m=63", 1'b1, 1'b1, 2, 63);
      total("R6 wide clamp n=15 m=5", 1'b1, 1'b1, 15, 5);

      // R5 wide placement
      pattern("R5 wide m=000101", 1'b0, 1'b1, 3, 5);
      pattern("R5 wide m=111111", 1'b1, 1'b1, 1, 63);

      // R4 / R3 wide slow run lengths
      apply(1'b1, 1'b1, 9, 0);
      settle(1'b1, 1'b1);
      bad = 0;
      for (int j = 0; j < 10; j++) begin
         next_run(len);
         if (len != 36) bad++;
      end
      check("R4 R3 wide slow run length n=9", bad, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule